// File: doc/BRIEF.md
# Broadcast Mesh Matrix Multiply Array

This block is a square grid of N by N processing elements that together form the product of two block matrices, Do = W × Di, in fixed-point signed arithmetic. Element (i,j) holds exactly one block of each operand and one block of the result, so no operand is stored twice anywhere in the grid. Every grid row shares one row bus and every grid column shares one column bus.

A start pulse loads all operand blocks into their elements and clears every accumulator. A sequencer then walks through N steps. In step k, the elements of grid column k drive their W block onto their row buses, and the elements of grid row k drive their Di block onto their column buses. Every element latches what it receives into a transfer buffer. In the following cycle it multiplies the two buffered values and adds the product into its own accumulator. A source element takes its own local block and does not read it back off the bus. Each step therefore takes two cycles: one to broadcast and one to accumulate. After the last accumulate the block raises a one-cycle done pulse, and every element then holds its finished result.

Top module: `mesh_mm_array`

## Requirements
- R1: A start pulse accepted while idle captures every W and Di block from the input ports. Changes on those inputs before the next accepted start have no effect on the results.
- R2: Reset clears all result outputs to zero and lowers busy and done. An accepted start clears every accumulator, so a result never carries anything from an earlier run.
- R3: In step k, element (i,j) receives W(i,k) over row bus i. The element in column k uses its own block.
- R4: In step k, element (i,j) receives Di(k,j) over column bus j. The element in row k uses its own block.
- R5: After a run, result output (i,j) equals the signed sum over k of W(i,k)·Di(k,j), computed at full precision in the accumulator width. This holds at the most negative operand values.
- R6: Done is high for exactly one cycle. It appears 2N clock edges after the edge that accepts start. Busy is high from the edge after start until done.
- R7: A start pulse that arrives while busy is ignored. It does not alter the results and does not cause a second done.
- R8: Block (i,j) sits at flat index i·N+j in w_in, di_in and do_out. Operands are OPW-bit two's complement and results are ACCW-bit two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| w_in | input | N·N·OPW | W blocks, index i·N+j |
| di_in | input | N·N·OPW | Di blocks, index i·N+j |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| do_out | output | N·N·ACCW | Result blocks, index i·N+j |

## Verification
Identity W against a random Di isolates routing. A wrong row or column selection permutes the result, and a source element that reads the bus shows up as a stale value. A fully random signed pair checks the sign handling of the product. Uniform most-negative operands check that the accumulator sign-extends and does not overflow. Further runs check the following:
- Back-to-back runs with different data separate a cleared accumulator from a stale one.
- Changing the inputs and pulsing start mid-run separates captured operands from live ones.
- An all-zero run checks the clear path.

// File: rtl/mesh_pkg.sv
package mesh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BCAST = 2'd1,
        ST_MAC   = 2'd2,
        ST_FIN   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic load;   // capture own operand blocks
        logic clr;    // zero the accumulator
        logic cap;    // latch bus values into transfer buffers
        logic mac;    // multiply-accumulate buffered operands
    } pe_ctl_t;

    function automatic int step_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mesh_seq.sv
module mesh_seq
    import mesh_pkg::*;
#(
    parameter int N  = 4,
    parameter int SW = step_bits(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output pe_ctl_t       ctl,
    output logic [SW-1:0] step,
    output logic          busy,
    output logic          done
);
    localparam logic [SW-1:0] LAST = SW'(N - 1);

    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            step  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_BCAST;
                    step  <= '0;
                end
                ST_BCAST: state <= ST_MAC;
                ST_MAC: begin
                    if (step == LAST) begin
                        state <= ST_FIN;
                    end else begin
                        step  <= step + 1'b1;
                        state <= ST_BCAST;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.load = (state == ST_IDLE) && start;
        ctl.clr  = (state == ST_IDLE) && start;
        ctl.cap  = (state == ST_BCAST);
        ctl.mac  = (state == ST_MAC);
        busy     = (state == ST_BCAST) || (state == ST_MAC);
        done     = (state == ST_FIN);
    end

    // R6: done lasts a single cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R6: done only follows an accumulate cycle
    a_r6_done_after_mac: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(ctl.mac));
    // R3: step index stays inside the grid while running
    a_r3_step_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(step) < N));
    // R7: no load while a run is in progress
    a_r7_no_load_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ctl.load);

endmodule

// File: rtl/mesh_bus.sv
module mesh_bus #(
    parameter int N   = 4,
    parameter int OPW = 16,
    parameter int SW  = 2
) (
    input  logic [N*N-1:0][OPW-1:0] w_own,
    input  logic [N*N-1:0][OPW-1:0] di_own,
    input  logic [SW-1:0]           step,
    output logic [N-1:0][OPW-1:0]   row_bus,
    output logic [N-1:0][OPW-1:0]   col_bus
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_lane
            // row bus g carries W from the element in column step
            always_comb row_bus[g] = w_own[g*N + int'(step)];
            // column bus g carries Di from the element in row step
            always_comb col_bus[g] = di_own[int'(step)*N + g];
        end
    endgenerate
endmodule

// File: rtl/mesh_pe.sv
module mesh_pe
    import mesh_pkg::*;
#(
    parameter int OPW  = 16,
    parameter int ACCW = 40,
    parameter int SW   = 2,
    parameter int ROW  = 0,
    parameter int COL  = 0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  pe_ctl_t                ctl,
    input  logic [SW-1:0]          step,
    input  logic [OPW-1:0]         w_in,
    input  logic [OPW-1:0]         di_in,
    input  logic [OPW-1:0]         row_bus,
    input  logic [OPW-1:0]         col_bus,
    output logic [OPW-1:0]         w_own,
    output logic [OPW-1:0]         di_own,
    output logic signed [ACCW-1:0] acc
);
    localparam int PW = 2 * OPW;

    logic signed [OPW-1:0] wbuf, dbuf;
    logic        [OPW-1:0] w_sel, d_sel;
    logic signed [PW-1:0]  prod;

    // the source element uses its own block rather than the bus copy
    always_comb begin
        w_sel = (step == SW'(COL)) ? w_own  : row_bus;
        d_sel = (step == SW'(ROW)) ? di_own : col_bus;
        prod  = wbuf * dbuf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w_own  <= '0;
            di_own <= '0;
            wbuf   <= '0;
            dbuf   <= '0;
            acc    <= '0;
        end else begin
            if (ctl.load) begin
                w_own  <= w_in;
                di_own <= di_in;
            end
            if (ctl.cap) begin
                wbuf <= $signed(w_sel);
                dbuf <= $signed(d_sel);
            end
            if (ctl.clr)
                acc <= '0;
            else if (ctl.mac)
                acc <= acc + ACCW'(prod);
        end
    end

    // R2: an accepted start leaves the accumulator at zero
    a_r2_clear: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> (acc == '0));
    // R1: owned blocks change only on a load
    a_r1_own_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl.load |=> ($stable(w_own) && $stable(di_own)));
    // R5: the accumulator moves only on accumulate or clear
    a_r5_acc_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl.mac && !ctl.clr) |=> $stable(acc));

endmodule

// File: rtl/mesh_mm_array.sv
module mesh_mm_array
    import mesh_pkg::*;
#(
    parameter int N    = 4,
    parameter int OPW  = 16,
    parameter int ACCW = 40
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [N*N-1:0][OPW-1:0]   w_in,
    input  logic [N*N-1:0][OPW-1:0]   di_in,
    output logic                      busy,
    output logic                      done,
    output logic [N*N-1:0][ACCW-1:0]  do_out
);
    localparam int SW = step_bits(N);

    pe_ctl_t                 ctl;
    logic [SW-1:0]           step;
    logic [N*N-1:0][OPW-1:0] w_own, di_own;
    logic [N-1:0][OPW-1:0]   row_bus, col_bus;

    mesh_seq #(.N(N), .SW(SW)) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .ctl(ctl), .step(step), .busy(busy), .done(done)
    );

    mesh_bus #(.N(N), .OPW(OPW), .SW(SW)) u_bus (
        .w_own(w_own), .di_own(di_own), .step(step),
        .row_bus(row_bus), .col_bus(col_bus)
    );

    generate
        for (genvar r = 0; r < N; r++) begin : g_row
            for (genvar c = 0; c < N; c++) begin : g_col
                logic signed [ACCW-1:0] acc_q;
                mesh_pe #(.OPW(OPW), .ACCW(ACCW), .SW(SW), .ROW(r), .COL(c)) u_pe (
                    .clk(clk), .rst(rst), .ctl(ctl), .step(step),
                    .w_in(w_in[r*N+c]), .di_in(di_in[r*N+c]),
                    .row_bus(row_bus[r]), .col_bus(col_bus[c]),
                    .w_own(w_own[r*N+c]), .di_own(di_own[r*N+c]),
                    .acc(acc_q)
                );
                assign do_out[r*N+c] = acc_q;
            end
        end
    endgenerate

    // R6: done and busy are never high together
    a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

endmodule

// File: tb/sim_mesh_mm_array.sv
module sim_mesh_mm_array;
    localparam int N      = 4;
    localparam int OPW    = 16;
    localparam int ACCW   = 40;
    localparam int CLK_NS = 10;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [N*N-1:0][OPW-1:0]  w_in, di_in;
    logic                     busy, done;
    logic [N*N-1:0][ACCW-1:0] do_out;

    int n_chk = 0, n_bad = 0, n_done = 0, wd = 0;
    longint exp_q[$];

    always #(CLK_NS/2) clk = ~clk;

    mesh_mm_array #(.N(N), .OPW(OPW), .ACCW(ACCW)) u0 (
        .clk(clk), .rst(rst), .start(start), .w_in(w_in), .di_in(di_in),
        .busy(busy), .done(done), .do_out(do_out)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver side: compute the signed matrix product and queue it
    task automatic push_expected();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                longint s = 0;
                for (int k = 0; k < N; k++)
                    s += longint'($signed(w_in[i*N+k])) * longint'($signed(di_in[k*N+j]));
                exp_q.push_back(s);
            end
    endtask

    // monitor: pop and compare on every done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            n_done++;
            for (int idx = 0; idx < N*N; idx++) begin
                longint e;
                if (exp_q.size() == 0) begin
                    check("R7 unexpected result", 1, 0);
                    break;
                end
                e = exp_q.pop_front();
                check("R5 result", longint'($signed(do_out[idx])), e);
            end
        end
    end

    // run one product; optionally disturb the inputs mid-run (R1, R7)
    task automatic run(input bit disturb);
        int cnt = 0;
        push_expected();
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        check("R6 busy after start", busy, 1);
        while (!done && cnt < 10*N) begin
            if (disturb && cnt == 3) begin
                for (int x = 0; x < N*N; x++) begin
                    w_in[x]  = $urandom;
                    di_in[x] = $urandom;
                end
                start = 1'b1;
            end
            @(posedge clk);
            cnt++;
            @(negedge clk) start = 1'b0;
        end
        check("R6 done latency", cnt, 2*N);
        for (int q = 0; q < 3; q++) begin
            @(negedge clk);
            check("R7 no second done", done, 0);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 50000) begin
                check("watchdog", 0, 1);
                $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        w_in = '0; di_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        check("R2 busy at reset", busy, 0);
        check("R2 done at reset", done, 0);
        for (int x = 0; x < N*N; x++)
            check("R2 output at reset", longint'($signed(do_out[x])), 0);

        // R3 R4: identity W exposes any routing error
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                w_in[i*N+j]  = (i == j) ? 16'd1 : 16'd0;
                di_in[i*N+j] = $urandom;
            end
        run(0);
        // R3 R4: identity Di, with W at index i*N+j (R8)
        for (int x = 0; x < N*N; x++) begin
            w_in[x]  = $urandom;
            di_in[x] = ((x / N) == (x % N)) ? 16'd1 : 16'd0;
        end
        run(0);
        // R5 random signed operands
        for (int x = 0; x < N*N; x++) begin
            w_in[x] = $urandom; di_in[x] = $urandom;
        end
        run(0);
        // R5 most negative corner
        for (int x = 0; x < N*N; x++) begin
            w_in[x] = 16'h8000; di_in[x] = 16'h8000;
        end
        run(0);
        // R2 all zero after a large result: accumulators must clear
        w_in = '0; di_in = '0;
        run(0);
        // R1 R7 inputs changed and start pulsed mid-run
        for (int x = 0; x < N*N; x++) begin
            w_in[x] = $urandom; di_in[x] = $urandom;
        end
        run(1);
        // R5 mixed signs, small values
        for (int x = 0; x < N*N; x++) begin
            w_in[x]  = 16'(x - 8);
            di_in[x] = 16'(7 - 2*x);
        end
        run(0);

        check("R6 done count", n_done, 7);
        check("R7 queue empty", exp_q.size(), 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule